// File: doc/BRIEF.md
# Remote-Word Attraction Buffer

This block sits beside one cluster's local cache module in a clustered processor whose data cache is interleaved word by word across clusters. Each cluster's module holds only its own slice of every cache line, so a load whose word lives in another cluster normally pays the remote latency. The attraction buffer keeps copies of remote subblocks. When a remote load misses the buffer, the block asks the interconnect for the whole remote subblock and installs every word of it. A later load to any of those words is then answered in one cycle, as if it had hit locally. A strided stream that touches two words of the same remote subblock therefore finds half of its accesses local.

Coherence needs no snooping. Loads share clean copies freely, so the same remote word may sit in several clusters' buffers. Every store is announced to the other clusters as an invalidate, so that modified data lives in one buffer only. At the end of a loop, software raises a flush command. The buffer then walks all its entries, writes dirty subblocks back to their home modules, empties itself and pulses a done signal. The word address splits into a home-cluster field (lowest bits), a word-within-subblock field (next bits) and a line tag (the rest).

Top module: `attract_buf`

## Requirements
- R1: A load whose home field (req_addr[1:0]) is not the own cluster and whose {tag, home} matches a valid entry sets resp_valid and resp_hit one cycle after acceptance, with the word picked by req_addr[2] from that entry.
- R2: A remote load that misses raises fetch_req for exactly one cycle, one cycle after acceptance, carrying the tag (req_addr[31:3]) and home. busy stays high until fetch_rsp_valid arrives. One cycle after that, resp_valid is high, resp_hit is low and the requested word from fetch_rsp_data comes back (word i in bits i*32 up).
- R3: A fill installs every word of the fetched subblock, so a following load to the other word of the same subblock (address plus 4) hits.
- R4: Fills replace entries in round-robin order: after eight fills of distinct subblocks, the ninth fill evicts the first. A dirty victim is written back in the fill cycle on the writeback port with mask 2'b11.
- R5: A store that hits updates the word and marks the entry dirty. It is acknowledged one cycle later with resp_valid and resp_hit, and it broadcasts inv_out_valid with its tag and home. A load never raises inv_out_valid.
- R6: A store that misses is written around: one cycle later wb_valid rises with only the mask bit of req_addr[2] set and the store data in that word, along with inv_out_valid. No entry is allocated, so a following load of that address misses.
- R7: inv_in_valid with a {tag, home} held in the buffer invalidates that entry without any writeback, so the next load to it misses.
- R8: A flush accepted while idle keeps busy high, writes back each dirty entry once with mask 2'b11 and leaves all entries invalid. flush_done pulses for one cycle on the ninth clock edge counted from the acceptance edge, with busy low.
- R9: A request whose home is the own cluster (MY_CLUSTER, default 0) is ignored. So is a request presented while busy is high. Neither produces resp_valid or fetch_req.
- R10: After reset, busy, resp_valid, fetch_req, wb_valid, inv_out_valid and flush_done are low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request from the cluster |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Word address {tag, word select, home cluster} |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Miss or flush in progress; requests are not taken |
| resp_valid | output | 1 | Load data or store acknowledge |
| resp_hit | output | 1 | Response came from the buffer |
| resp_rdata | output | 32 | Load data |
| fetch_req | output | 1 | One-cycle request for a remote subblock |
| fetch_tag | output | 29 | Line tag of the fetch |
| fetch_home | output | 2 | Home cluster of the fetch |
| fetch_rsp_valid | input | 1 | Fetched subblock is present |
| fetch_rsp_data | input | 64 | Fetched subblock, word i at bits i*32 |
| wb_valid | output | 1 | Write to a home module |
| wb_tag | output | 29 | Line tag of the write |
| wb_home | output | 2 | Home cluster of the write |
| wb_mask | output | 2 | Words of the subblock being written |
| wb_data | output | 64 | Write data, word i at bits i*32 |
| inv_out_valid | output | 1 | Invalidate broadcast to other buffers |
| inv_out_tag | output | 29 | Tag of the broadcast |
| inv_out_home | output | 2 | Home of the broadcast |
| inv_in_valid | input | 1 | Invalidate from another cluster |
| inv_in_tag | input | 29 | Tag to invalidate |
| inv_in_home | input | 2 | Home to invalidate |
| flush_req | input | 1 | End-of-loop flush command |
| flush_done | output | 1 | One-cycle flush completion pulse |

## Verification
A corrupted entry tag or valid bit shows at the ports on the very next load to that subblock. An extra fetch_req appears one cycle after acceptance, or a hit appears where a miss is due. A corrupted stored word shows as wrong resp_rdata one cycle after a load. A lost dirty bit shows as a missing writeback, either at the eviction that pushes the entry out or somewhere inside the nine-edge flush window. A wrong replacement pointer shows when the ninth fill evicts a subblock other than the first, which the next load of the first subblock exposes.

// File: rtl/attract_buf_pkg.sv
package attract_buf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MISS  = 2'd1,
    ST_FLUSH = 2'd2
  } ab_state_e;
endpackage

// File: rtl/ab_rst_sync.sv
module ab_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/ab_match.sv
module ab_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 29,
  parameter int CL_W    = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ENTRIES-1:0][CL_W-1:0]  homes,
  input  logic [TAG_W-1:0]              key_tag,
  input  logic [CL_W-1:0]               key_home,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m[g] = vld[g] && (tags[g] == key_tag) && (homes[g] == key_home);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (m[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |m;
endmodule

// File: rtl/ab_rr_ptr.sv
module ab_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) ptr_d = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end
endmodule

// File: rtl/ab_ctrl.sv
module ab_ctrl
  import attract_buf_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_ok,
  input  logic             req_write,
  input  logic             req_hit,
  input  logic             flush_req,
  input  logic             rsp_valid,
  output logic             busy,
  output logic             take_req,
  output logic             take_miss,
  output logic             fill,
  output logic             fl_step,
  output logic [IDX_W-1:0] fl_idx,
  output logic             flush_done
);
  ab_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_d;
  logic             fl_last;
  logic             idx_en;

  assign busy      = (st_q != ST_IDLE);
  assign take_req  = (st_q == ST_IDLE) && !flush_req && req_ok;
  assign take_miss = take_req && !req_write && !req_hit;
  assign fill      = (st_q == ST_MISS) && rsp_valid;
  assign fl_step   = (st_q == ST_FLUSH);
  assign fl_last   = fl_step && (fl_idx == IDX_W'(ENTRIES - 1));

  always_comb begin
    st_d   = st_q;
    idx_d  = fl_idx;
    idx_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (flush_req) begin
          st_d   = ST_FLUSH;
          idx_d  = '0;
          idx_en = 1'b1;
        end else if (take_miss) begin
          st_d = ST_MISS;
        end
      end
      ST_MISS:  if (fill) st_d = ST_IDLE;
      ST_FLUSH: begin
        idx_en = 1'b1;
        idx_d  = fl_idx + 1'b1;
        if (fl_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      fl_idx     <= '0;
      flush_done <= 1'b0;
    end else begin
      st_q       <= st_d;
      flush_done <= fl_last;
      if (idx_en) fl_idx <= idx_d;
    end
  end
endmodule

// File: rtl/attract_buf.sv
module attract_buf #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int N_CLUST    = 4,
  parameter int SUB_WORDS  = 2,
  parameter int ENTRIES    = 8,
  parameter int MY_CLUSTER = 0,
  localparam int CL_W  = $clog2(N_CLUST),
  localparam int SW_W  = $clog2(SUB_WORDS),
  localparam int TAG_W = ADDR_W - CL_W - SW_W,
  localparam int SB_W  = SUB_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              fetch_req,
  output logic [TAG_W-1:0]  fetch_tag,
  output logic [CL_W-1:0]   fetch_home,
  input  logic              fetch_rsp_valid,
  input  logic [SB_W-1:0]   fetch_rsp_data,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [CL_W-1:0]   wb_home,
  output logic [SUB_WORDS-1:0] wb_mask,
  output logic [SB_W-1:0]   wb_data,
  output logic              inv_out_valid,
  output logic [TAG_W-1:0]  inv_out_tag,
  output logic [CL_W-1:0]   inv_out_home,
  input  logic              inv_in_valid,
  input  logic [TAG_W-1:0]  inv_in_tag,
  input  logic [CL_W-1:0]   inv_in_home,
  input  logic              flush_req,
  output logic              flush_done
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic srst_n;

  // entry storage
  logic [ENTRIES-1:0]                            vld_q, vld_d, drt_q, drt_d;
  logic [ENTRIES-1:0][TAG_W-1:0]                 tag_q, tag_d;
  logic [ENTRIES-1:0][CL_W-1:0]                  hom_q, hom_d;
  logic [ENTRIES-1:0][SUB_WORDS-1:0][DATA_W-1:0] dat_q, dat_d;

  // request decode
  logic [CL_W-1:0]  req_home;
  logic [SW_W-1:0]  req_sel;
  logic [TAG_W-1:0] req_tag;
  logic             req_ok;

  logic             hit, ihit;
  logic [IDX_W-1:0] hidx, iidx, ptr, fl_idx;
  logic             take_req, take_miss, fill, fl_step;
  logic [SW_W-1:0]  pend_sel;
  logic [SUB_WORDS-1:0][DATA_W-1:0] rsp_w;

  // output next values
  logic                             resp_v_d, resp_hit_d;
  logic [DATA_W-1:0]                resp_dat_d;
  logic                             wb_v_d;
  logic [TAG_W-1:0]                 wb_tag_d;
  logic [CL_W-1:0]                  wb_home_d;
  logic [SUB_WORDS-1:0]             wb_mask_d;
  logic [SUB_WORDS-1:0][DATA_W-1:0] wb_dat_d, wb_dat_q;
  logic                             st_hit;

  assign req_home = req_addr[CL_W-1:0];
  assign req_sel  = req_addr[CL_W +: SW_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_ok   = req_valid && (req_home != CL_W'(MY_CLUSTER));
  assign rsp_w    = fetch_rsp_data;
  assign wb_data  = wb_dat_q;
  assign st_hit   = take_req && req_write && hit;

  ab_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CL_W(CL_W)) u_req_match (
    .vld      (vld_q),
    .tags     (tag_q),
    .homes    (hom_q),
    .key_tag  (req_tag),
    .key_home (req_home),
    .hit      (hit),
    .idx      (hidx)
  );

  ab_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CL_W(CL_W)) u_inv_match (
    .vld      (vld_q),
    .tags     (tag_q),
    .homes    (hom_q),
    .key_tag  (inv_in_tag),
    .key_home (inv_in_home),
    .hit      (ihit),
    .idx      (iidx)
  );

  ab_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (srst_n),
    .adv   (fill),
    .ptr   (ptr)
  );

  ab_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst_n      (srst_n),
    .req_ok     (req_ok),
    .req_write  (req_write),
    .req_hit    (hit),
    .flush_req  (flush_req),
    .rsp_valid  (fetch_rsp_valid),
    .busy       (busy),
    .take_req   (take_req),
    .take_miss  (take_miss),
    .fill       (fill),
    .fl_step    (fl_step),
    .fl_idx     (fl_idx),
    .flush_done (flush_done)
  );

  // entry next state
  always_comb begin
    vld_d = vld_q;
    drt_d = drt_q;
    tag_d = tag_q;
    hom_d = hom_q;
    dat_d = dat_q;
    if (st_hit) begin
      dat_d[hidx][req_sel] = req_wdata;
      drt_d[hidx]          = 1'b1;
    end
    if (fill) begin
      vld_d[ptr] = 1'b1;
      drt_d[ptr] = 1'b0;
      tag_d[ptr] = fetch_tag;
      hom_d[ptr] = fetch_home;
      dat_d[ptr] = rsp_w;
    end
    if (fl_step) begin
      vld_d[fl_idx] = 1'b0;
      drt_d[fl_idx] = 1'b0;
    end
    if (inv_in_valid && ihit) begin
      vld_d[iidx] = 1'b0;
      drt_d[iidx] = 1'b0;
    end
  end

  // writeback next state: store miss, dirty victim, flush step are exclusive
  always_comb begin
    wb_v_d    = 1'b0;
    wb_tag_d  = wb_tag;
    wb_home_d = wb_home;
    wb_mask_d = wb_mask;
    wb_dat_d  = wb_dat_q;
    if (take_req && req_write && !hit) begin
      wb_v_d             = 1'b1;
      wb_tag_d           = req_tag;
      wb_home_d          = req_home;
      wb_mask_d          = '0;
      wb_mask_d[req_sel] = 1'b1;
      wb_dat_d           = '0;
      wb_dat_d[req_sel]  = req_wdata;
    end else if (fill && vld_q[ptr] && drt_q[ptr]) begin
      wb_v_d    = 1'b1;
      wb_tag_d  = tag_q[ptr];
      wb_home_d = hom_q[ptr];
      wb_mask_d = '1;
      wb_dat_d  = dat_q[ptr];
    end else if (fl_step && vld_q[fl_idx] && drt_q[fl_idx]) begin
      wb_v_d    = 1'b1;
      wb_tag_d  = tag_q[fl_idx];
      wb_home_d = hom_q[fl_idx];
      wb_mask_d = '1;
      wb_dat_d  = dat_q[fl_idx];
    end
  end

  // response next state
  always_comb begin
    resp_v_d   = (take_req && (req_write || hit)) || fill;
    resp_hit_d = take_req && hit;
    resp_dat_d = fill ? rsp_w[pend_sel] : dat_q[hidx][req_sel];
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= '0;
      drt_q <= '0;
      tag_q <= '0;
      hom_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      drt_q <= drt_d;
      tag_q <= tag_d;
      hom_q <= hom_d;
      dat_q <= dat_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_rdata    <= '0;
      fetch_req     <= 1'b0;
      fetch_tag     <= '0;
      fetch_home    <= '0;
      pend_sel      <= '0;
      wb_valid      <= 1'b0;
      wb_tag        <= '0;
      wb_home       <= '0;
      wb_mask       <= '0;
      wb_dat_q      <= '0;
      inv_out_valid <= 1'b0;
      inv_out_tag   <= '0;
      inv_out_home  <= '0;
    end else begin
      resp_valid    <= resp_v_d;
      resp_hit      <= resp_hit_d;
      fetch_req     <= take_miss;
      wb_valid      <= wb_v_d;
      inv_out_valid <= take_req && req_write;
      if (resp_v_d) resp_rdata <= resp_dat_d;
      if (take_miss) begin
        fetch_tag  <= req_tag;
        fetch_home <= req_home;
        pend_sel   <= req_sel;
      end
      if (wb_v_d) begin
        wb_tag   <= wb_tag_d;
        wb_home  <= wb_home_d;
        wb_mask  <= wb_mask_d;
        wb_dat_q <= wb_dat_d;
      end
      if (take_req && req_write) begin
        inv_out_tag  <= req_tag;
        inv_out_home <= req_home;
      end
    end
  end
endmodule

// File: rtl/attract_buf_chk.sv
module attract_buf_chk #(
  parameter int CL_W       = 2,
  parameter int SUB_WORDS  = 2,
  parameter int MY_CLUSTER = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [CL_W-1:0]      req_home,
  input logic                 flush_req,
  input logic                 busy,
  input logic                 resp_valid,
  input logic                 fetch_req,
  input logic                 wb_valid,
  input logic [SUB_WORDS-1:0] wb_mask,
  input logic                 inv_out_valid,
  input logic                 flush_done
);
  // R2: a fetch leaves the block waiting for its response
  a_r2_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> busy);

  // R2: fetch request lasts one cycle
  a_r2_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);

  // R5: broadcasts come only from accepted stores
  a_r5_inv_from_store: assert property (@(posedge clk) disable iff (!rst_n)
    inv_out_valid |-> $past(req_valid && req_write && !busy));

  // R9: own-cluster requests are ignored
  a_r9_local_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !flush_req && req_home == CL_W'(MY_CLUSTER))
      |=> (!resp_valid && !fetch_req));

  // R8: done is a single pulse and the block is idle by then
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !busy);

  // R4: every write to a home module carries at least one word
  a_r4_wb_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_mask != '0));
endmodule

bind attract_buf attract_buf_chk #(
  .CL_W       (CL_W),
  .SUB_WORDS  (SUB_WORDS),
  .MY_CLUSTER (MY_CLUSTER)
) u_chk (
  .clk           (clk),
  .rst_n         (srst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_home      (req_addr[CL_W-1:0]),
  .flush_req     (flush_req),
  .busy          (busy),
  .resp_valid    (resp_valid),
  .fetch_req     (fetch_req),
  .wb_valid      (wb_valid),
  .wb_mask       (wb_mask),
  .inv_out_valid (inv_out_valid),
  .flush_done    (flush_done)
);

// File: tb/attract_buf_bench.sv
module attract_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        busy, resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        fetch_req;
  logic [28:0] fetch_tag;
  logic [1:0]  fetch_home;
  logic        fetch_rsp_valid;
  logic [63:0] fetch_rsp_data;
  logic        wb_valid;
  logic [28:0] wb_tag;
  logic [1:0]  wb_home;
  logic [1:0]  wb_mask;
  logic [63:0] wb_data;
  logic        inv_out_valid;
  logic [28:0] inv_out_tag;
  logic [1:0]  inv_out_home;
  logic        inv_in_valid;
  logic [28:0] inv_in_tag;
  logic [1:0]  inv_in_home;
  logic        flush_req, flush_done;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  attract_buf u_attract_buf (.*);

  function automatic logic [31:0] memw(input logic [31:0] a);
    return a * 32'h0001_0003 + 32'h0BAD_0001;
  endfunction

  // remote memory model: answers a fetch one cycle later
  always @(negedge clk) begin
    fetch_rsp_valid <= fetch_req;
    fetch_rsp_data  <= {memw({fetch_tag, 1'b1, fetch_home}),
                        memw({fetch_tag, 1'b0, fetch_home})};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // drive one request; returns 1 ns after the acceptance edge
  task automatic drive(input bit wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  logic        last_wb;
  logic [1:0]  last_wb_mask;
  logic [63:0] last_wb_data;

  task automatic load(input logic [31:0] a, input bit exp_hit, input logic [31:0] exp_d, input string rq);
    drive(1'b0, a, 32'h0);
    if (exp_hit) begin
      chk(resp_valid && resp_hit, rq, {resp_valid, resp_hit}, 2'b11);
      chk(resp_rdata == exp_d, rq, resp_rdata, exp_d);
      chk(!fetch_req, rq, fetch_req, 0);
    end else begin
      chk(fetch_req && busy && !resp_valid, "R2", {fetch_req, busy, resp_valid}, 3'b110);
      chk(fetch_tag == a[31:3] && fetch_home == a[1:0], "R2", {fetch_tag, fetch_home}, {a[31:3], a[1:0]});
      @(posedge clk); #1;
      last_wb = wb_valid; last_wb_mask = wb_mask; last_wb_data = wb_data;
      chk(resp_valid && !resp_hit && !busy, rq, {resp_valid, resp_hit, busy}, 3'b100);
      chk(resp_rdata == exp_d, rq, resp_rdata, exp_d);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d, input bit exp_hit, input string rq);
    drive(1'b1, a, d);
    chk(resp_valid && (resp_hit == exp_hit), rq, {resp_valid, resp_hit}, {1'b1, exp_hit});
    chk(inv_out_valid && inv_out_tag == a[31:3] && inv_out_home == a[1:0], "R5",
        {inv_out_valid, inv_out_tag, inv_out_home}, {1'b1, a[31:3], a[1:0]});
    if (!exp_hit) begin
      chk(wb_valid && wb_mask == (2'b01 << a[2]), "R6", {wb_valid, wb_mask}, {1'b1, 2'b01 << a[2]});
      chk(wb_data[a[2]*32 +: 32] == d, "R6", wb_data[a[2]*32 +: 32], d);
    end else begin
      chk(!wb_valid, "R5", wb_valid, 0);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic        hit;
    logic [31:0] addr;
    logic [31:0] data;   // store data, or expected load data (0 = memory value)
  } vec_t;

  // stride of four words, all homed in cluster 3
  localparam vec_t VEC [11] = '{
    '{1'b0, 1'b0, 32'd3,  32'd0},
    '{1'b0, 1'b1, 32'd7,  32'd0},
    '{1'b0, 1'b0, 32'd11, 32'd0},
    '{1'b0, 1'b1, 32'd15, 32'd0},
    '{1'b0, 1'b0, 32'd19, 32'd0},
    '{1'b0, 1'b1, 32'd23, 32'd0},
    '{1'b1, 1'b1, 32'd7,  32'hDEAD_0007},
    '{1'b0, 1'b1, 32'd7,  32'hDEAD_0007},
    '{1'b0, 1'b1, 32'd3,  32'd0},
    '{1'b1, 1'b1, 32'd15, 32'h1111_0015},
    '{1'b0, 1'b1, 32'd15, 32'h1111_0015}
  };

  function automatic logic [31:0] kaddr(input int i);
    return 32'((i + 20) * 8 + 2);
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    inv_in_valid = 1'b0; inv_in_tag = '0; inv_in_home = '0; flush_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R10: reset state
    chk(!busy && !resp_valid && !fetch_req && !wb_valid && !inv_out_valid && !flush_done, "R10",
        {busy, resp_valid, fetch_req, wb_valid, inv_out_valid, flush_done}, 0);

    // R1 R3 R5: vector table
    for (int i = 0; i < 11; i++) begin
      logic [31:0] ed;
      ed = (VEC[i].data != 0) ? VEC[i].data : memw(VEC[i].addr);
      if (VEC[i].wr) store(VEC[i].addr, VEC[i].data, VEC[i].hit, "R5");
      else if (VEC[i].hit) load(VEC[i].addr, 1'b1, ed, "R1/R3");
      else load(VEC[i].addr, 1'b0, ed, "R2");
    end

    // R10: entries invalid after reset, shown by the first load missing (done above: 3 missed)
    // R9: own-cluster address ignored
    drive(1'b0, 32'd8, 32'h0);
    chk(!resp_valid && !fetch_req && !busy, "R9", {resp_valid, fetch_req, busy}, 0);

    // R7: invalidate from another cluster for subblock of 19/23
    @(negedge clk);
    inv_in_valid = 1'b1; inv_in_tag = 29'd2; inv_in_home = 2'd3;
    @(posedge clk); #1;
    inv_in_valid = 1'b0;
    chk(!wb_valid, "R7", wb_valid, 0);
    load(32'd23, 1'b0, memw(32'd23), "R7");
    load(32'd19, 1'b1, memw(32'd19), "R7");

    // R6: store miss writes around, no allocation
    store(32'd101, 32'hCAFE_0101, 1'b0, "R6");
    load(32'd101, 1'b0, memw(32'd101), "R6");

    // flush to a known empty state, then R4 round robin
    @(negedge clk); flush_req = 1'b1;
    @(posedge clk); #1; flush_req = 1'b0;
    while (!flush_done) begin @(posedge clk); #1; end
    for (int i = 0; i < 8; i++) load(kaddr(i), 1'b0, memw(kaddr(i)), "R4");
    for (int i = 0; i < 8; i++) load(kaddr(i) + 4, 1'b1, memw(kaddr(i) + 4), "R4");
    store(kaddr(0), 32'hBEEF_0000, 1'b1, "R5");
    load(kaddr(8), 1'b0, memw(kaddr(8)), "R4");
    chk(last_wb && last_wb_mask == 2'b11, "R4", {last_wb, last_wb_mask}, 3'b111);
    chk(last_wb_data == {memw(kaddr(0) + 4), 32'hBEEF_0000}, "R4", last_wb_data,
        {memw(kaddr(0) + 4), 32'hBEEF_0000});
    load(kaddr(0), 1'b0, memw(kaddr(0)), "R4");
    load(kaddr(2), 1'b1, memw(kaddr(2)), "R4");

    // R8: flush with two dirty entries; R9: request held during flush is not taken
    store(kaddr(2), 32'h2222_0002, 1'b1, "R5");
    store(kaddr(3), 32'h3333_0003, 1'b1, "R5");
    begin
      int n, nwb, nresp;
      n = 0; nwb = 0; nresp = 0;
      @(negedge clk);
      flush_req = 1'b1;
      @(posedge clk); #1;
      flush_req = 1'b0;
      req_valid = 1'b1; req_write = 1'b0; req_addr = kaddr(5);
      n = 1;
      chk(busy, "R8", busy, 1);
      while (!flush_done && n < 40) begin
        @(posedge clk); #1;
        n++;
        if (wb_valid) begin
          nwb++;
          chk(wb_mask == 2'b11, "R8", wb_mask, 2'b11);
        end
        if (resp_valid || fetch_req) nresp++;
      end
      req_valid = 1'b0;
      chk(n == 9, "R8", n, 9);
      chk(nwb == 2, "R8", nwb, 2);
      chk(nresp == 0, "R9", nresp, 0);
      chk(!busy, "R8", busy, 0);
      @(posedge clk); #1;
      chk(!flush_done, "R8", flush_done, 0);
    end
    load(kaddr(2), 1'b0, memw(kaddr(2)), "R8");
    load(kaddr(5), 1'b0, memw(kaddr(5)), "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule